// File: doc/BRIEF.md
# Nine-Level Carrier-Stack PWM Modulator

The block turns three signed phase references into gate commands for a three-phase, nine-level clamped converter. A single up/down counter forms a symmetric triangle. Eight carriers are derived from it, each shifted by a whole band height, so that the carriers stack into contiguous bands. The bands cover a signed range centred on zero. Before any comparison, a common-mode offset is removed from all three references. The offset is the midpoint between the largest and the smallest reference. Each corrected reference is then compared against all eight carriers.

For each phase the block produces eight comparator bits and a level index from 0 to 8. It also produces two ten-bit half-leg switch vectors. In each vector the upper five commands are the complements of the lower five, paired in a fixed order. A control loop supplies the references and the half-period setting. Both values are taken only at the carrier valley, so no command is disturbed in the middle of a period.

Top module: `mlpwm_top`

## Requirements
- R1: The counter runs 0, 1, ..., P, P-1, ..., 1, 0, so one period is 2P cycles. P is the half-period taken from `per_i`. Carrier k (k = 0..7) equals count - 4P + k*P. The carriers therefore share one amplitude and tile the range -4P..4P without overlap.
- R2: The offset is floor((max + min) / 2) over the three references. The corrected reference of each phase is its reference minus this offset.
- R3: Bit 8p+k of `cmp_o` (phase p: 0=a, 1=b, 2=c) is 1 when the corrected reference of phase p is strictly greater than carrier k. The bit is registered, so the value seen after a clock edge reflects the count held before that edge.
- R4: The field `lvl_o[4p+3:4p]` holds the number of set comparator bits of phase p. It saturates naturally at 0 and 8. The set bits always form a contiguous run starting at bit 0.
- R5: Per phase p and half h (0: carriers 0..3, 1: carriers 4..7), the 10-bit field at `sw_o[20p+10h +: 10]` is built from that half's four comparator bits c0..c3 as follows:
  - Bits 0..3 are c0..c3, and bit 4 is their OR.
  - Bit 5 is the inverse of bit 1, and bit 6 is the inverse of bit 0.
  - Bit 7 is the inverse of bit 2, bit 8 is the inverse of bit 3, and bit 9 is the inverse of bit 4.
- R6: References and P are taken only in a valley cycle (count 0). A change at any other time has no effect until the next valley. Inputs must be steady for two cycles before the valley edge.
- R7: A P value of 0 is treated as 1.
- R8: When `en` is low at a clock edge, the following outputs all read 0: the comparator bits, the level indices and the primary switch bits. The counter also returns to the valley, and the next enabled edge starts a new period at count 0.
- R9: After reset the comparator bits and level indices are 0, and each switch half reads 10'h3E0. The counter starts at the valley counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulator enable; low forces outputs off and restarts the carrier |
| per_i | input | 12 | Carrier half-period P in cycles (band height) |
| ref_a_i | input | 16 | Signed phase a reference |
| ref_b_i | input | 16 | Signed phase b reference |
| ref_c_i | input | 16 | Signed phase c reference |
| cmp_o | output | 24 | Comparator bits, phase p at bits 8p+7..8p |
| sw_o | output | 60 | Complementary switch commands, two halves per phase |
| lvl_o | output | 12 | Level index 0..8 per phase, 4 bits each |

## Verification
The assertions rely on two input assumptions. First, P never exceeds the 12-bit counter range, so that every carrier fits the comparison width. Second, references reach the offset stage without gaps, so its two registers always hold one matched set. The stimulus meets both. It holds each reference set and P steady for three cycles with `en` low before enabling. This makes the first valley land on a known edge and lets the two-cycle offset pipeline fill first. Later changes are applied only in mid-period, far from a valley, so the latching rule can be observed.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int NPH      = 3;
    localparam int NCAR     = 8;
    localparam int HALF_CAR = NCAR / 2;
    localparam int NPRI     = HALF_CAR + 1;
    localparam int NSW      = 2 * NPRI;
    localparam int LVL_W    = $clog2(NCAR + 1);

    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } dir_e;

    // one half-leg: primary commands low, their complements high
    typedef struct packed {
        logic [NPRI-1:0] cpl;
        logic [NPRI-1:0] pri;
    } sw_half_t;

    function automatic sw_half_t sw_map(input logic [HALF_CAR-1:0] hit);
        sw_half_t s;
        s.pri = {|hit, hit};
        s.cpl[0] = ~s.pri[1];
        s.cpl[1] = ~s.pri[0];
        s.cpl[2] = ~s.pri[2];
        s.cpl[3] = ~s.pri[3];
        s.cpl[4] = ~s.pri[4];
        return s;
    endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier
    import mlpwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic             valley_o
);

    logic [CNT_W-1:0] cnt_q, per_q, per_in, per_eff, cnt_inc, cnt_dec;
    dir_e             dir_q;

    assign per_in   = (per_i == '0) ? CNT_W'(1) : per_i;
    assign valley_o = (cnt_q == '0);
    assign per_eff  = valley_o ? per_in : per_q;
    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign cnt_dec  = cnt_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
            per_q <= CNT_W'(1);
        end else begin
            if (valley_o) per_q <= per_in;
            if (!en) begin
                cnt_q <= '0;
                dir_q <= DIR_UP;
            end else if (dir_q == DIR_UP) begin
                cnt_q <= cnt_inc;
                if (cnt_inc >= per_eff) dir_q <= DIR_DN;
            end else begin
                cnt_q <= cnt_dec;
                if (cnt_dec == '0) dir_q <= DIR_UP;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign per_o = per_eff;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= per_q);
    // R1
    valley_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> (dir_q == DIR_UP));
    // R6
    per_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valley_o |=> $stable(per_q));

endmodule

// File: rtl/mlpwm_offset.sv
module mlpwm_offset
    import mlpwm_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_i  [NPH],
    output logic signed [REF_W:0]   corr_o [NPH]
);

    localparam int CORR_W = REF_W + 1;

    logic signed [REF_W-1:0]  ref_q [NPH];
    logic signed [REF_W-1:0]  mx_c, mn_c, mx_q, mn_q, m01, n01;
    logic signed [CORR_W-1:0] sum_c, off_c;
    logic signed [CORR_W-1:0] corr_q [NPH];

    // two-level compare tree, registered before the offset adder
    always_comb begin
        m01  = (ref_i[0] > ref_i[1]) ? ref_i[0] : ref_i[1];
        n01  = (ref_i[0] < ref_i[1]) ? ref_i[0] : ref_i[1];
        mx_c = (m01 > ref_i[2]) ? m01 : ref_i[2];
        mn_c = (n01 < ref_i[2]) ? n01 : ref_i[2];
    end

    assign sum_c = CORR_W'(mx_q) + CORR_W'(mn_q);
    assign off_c = sum_c >>> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mx_q <= '0;
            mn_q <= '0;
            for (int p = 0; p < NPH; p++) begin
                ref_q[p]  <= '0;
                corr_q[p] <= '0;
            end
        end else begin
            mx_q <= mx_c;
            mn_q <= mn_c;
            for (int p = 0; p < NPH; p++) begin
                ref_q[p]  <= ref_i[p];
                corr_q[p] <= CORR_W'(ref_q[p]) - off_c;
            end
        end
    end

    assign corr_o = corr_q;

    // balance of the corrected set, checked only
    logic signed [CORR_W-1:0] cmax_a, cmin_a;
    logic signed [CORR_W:0]   cbal_a;
    always_comb begin
        cmax_a = corr_q[0];
        cmin_a = corr_q[0];
        for (int p = 1; p < NPH; p++) begin
            if (corr_q[p] > cmax_a) cmax_a = corr_q[p];
            if (corr_q[p] < cmin_a) cmin_a = corr_q[p];
        end
        cbal_a = (CORR_W+1)'(cmax_a) + (CORR_W+1)'(cmin_a);
    end

    // R2
    offset_balance_chk: assert property (@(posedge clk) disable iff (rst)
        (cbal_a == 0) || (cbal_a == 1));

endmodule

// File: rtl/mlpwm_phase.sv
module mlpwm_phase
    import mlpwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int CORR_W = 17
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [CORR_W-1:0] ref_i,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic [CNT_W-1:0]         per_i,
    output logic [NCAR-1:0]          cmp_o,
    output logic [LVL_W-1:0]         lvl_o
);

    localparam int CAR_W = CNT_W + 4;
    localparam int CMP_W = ((CAR_W > CORR_W) ? CAR_W : CORR_W) + 1;

    logic signed [CMP_W-1:0] cnt_s, per_s, ref_s;
    logic signed [CMP_W-1:0] car [NCAR];
    logic [NCAR-1:0]         hit;
    logic [LVL_W-1:0]        lvl_n;
    logic [NCAR-1:0]         cmp_q;
    logic [LVL_W-1:0]        lvl_q;

    assign cnt_s = $signed(CMP_W'(cnt_i));
    assign per_s = $signed(CMP_W'(per_i));
    assign ref_s = CMP_W'(ref_i);

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        assign car[k] = cnt_s + per_s * $signed(CMP_W'(k)) - (per_s <<< 2);
        assign hit[k] = ref_s > car[k];
    end

    always_comb begin
        lvl_n = '0;
        for (int k = 0; k < NCAR; k++) lvl_n = lvl_n + LVL_W'(hit[k]);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cmp_q <= '0;
            lvl_q <= '0;
        end else begin
            cmp_q <= hit;
            lvl_q <= lvl_n;
        end
    end

    assign cmp_o = cmp_q;
    assign lvl_o = lvl_q;

    // R8
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cmp_q == '0 && lvl_q == '0));
    // R4
    level_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cmp_q) == int'(lvl_q));
    // R4
    thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmp_q >> 1) & ~cmp_q) == '0);

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
    import mlpwm_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int CNT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [CNT_W-1:0]        per_i,
    input  logic signed [REF_W-1:0] ref_a_i,
    input  logic signed [REF_W-1:0] ref_b_i,
    input  logic signed [REF_W-1:0] ref_c_i,
    output logic [NPH*NCAR-1:0]     cmp_o,
    output logic [NPH*NSW*2-1:0]    sw_o,
    output logic [NPH*LVL_W-1:0]    lvl_o
);

    localparam int CORR_W = REF_W + 1;

    logic signed [REF_W-1:0]  ref_in   [NPH];
    logic signed [CORR_W-1:0] corr_pip [NPH];
    logic signed [CORR_W-1:0] ref_use  [NPH];
    logic signed [CORR_W-1:0] act_q    [NPH];
    logic [CNT_W-1:0]         cnt, per_eff;
    logic                     valley;

    assign ref_in[0] = ref_a_i;
    assign ref_in[1] = ref_b_i;
    assign ref_in[2] = ref_c_i;

    mlpwm_offset #(.REF_W(REF_W)) u_offset (
        .clk    (clk),
        .rst    (rst),
        .ref_i  (ref_in),
        .corr_o (corr_pip)
    );

    mlpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .per_i    (per_i),
        .cnt_o    (cnt),
        .per_o    (per_eff),
        .valley_o (valley)
    );

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPH; p++) begin
            if (rst) act_q[p] <= '0;
            else     act_q[p] <= ref_use[p];
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        logic [NCAR-1:0] cmp_p;
        sw_half_t        sw_lo, sw_hi;

        assign ref_use[p] = valley ? corr_pip[p] : act_q[p];

        mlpwm_phase #(.CNT_W(CNT_W), .CORR_W(CORR_W)) u_phase (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .ref_i (ref_use[p]),
            .cnt_i (cnt),
            .per_i (per_eff),
            .cmp_o (cmp_p),
            .lvl_o (lvl_o[p*LVL_W +: LVL_W])
        );

        assign sw_lo = sw_map(cmp_p[HALF_CAR-1:0]);
        assign sw_hi = sw_map(cmp_p[NCAR-1:HALF_CAR]);
        assign cmp_o[p*NCAR +: NCAR]        = cmp_p;
        assign sw_o[p*2*NSW +: NSW]         = sw_lo;
        assign sw_o[p*2*NSW + NSW +: NSW]   = sw_hi;

        // R6
        ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !valley |=> $stable(act_q[p]));
    end

endmodule

// File: tb/mlpwm_top_tb_top.sv
module mlpwm_top_tb_top;
    import mlpwm_pkg::*;

    localparam int REF_W = 16;
    localparam int CNT_W = 12;
    localparam int VN    = 8;

    // stimulus: P, refs a/b/c; expected corrected refs a/b/c
    localparam int V_P [VN] = '{100, 100, 50, 64, 37, 10, 1, 0};
    localparam int V_RA[VN] = '{200, 0, 30000, 101, -7, -3, 3, 2};
    localparam int V_RB[VN] = '{-100, 0, -30000, -20, -8, 0, -3, -2};
    localparam int V_RC[VN] = '{-100, 0, 0, 0, -9, 0, 1, 0};
    localparam int V_CA[VN] = '{150, 0, 30000, 61, 1, -1, 3, 2};
    localparam int V_CB[VN] = '{-150, 0, -30000, -60, 0, 2, -3, -2};
    localparam int V_CC[VN] = '{-150, 0, 0, -40, -1, 2, 1, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [CNT_W-1:0] per = '0;
    logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
    logic [NPH*NCAR-1:0]  cmp_o;
    logic [NPH*NSW*2-1:0] sw_o;
    logic [NPH*LVL_W-1:0] lvl_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    mlpwm_top #(.REF_W(REF_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .per_i(per),
        .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
        .cmp_o(cmp_o), .sw_o(sw_o), .lvl_o(lvl_o)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int cnt_at(input int j, input int p);
        int m;
        m = j % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    function automatic logic [7:0] exp_bits(input int r, input int c, input int p);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = (r > c - 4 * p + k * p);
        return b;
    endfunction

    function automatic logic [9:0] exp_half(input logic [3:0] pr);
        logic s5;
        s5 = |pr;
        return {~s5, ~pr[3], ~pr[2], ~pr[0], ~pr[1], s5, pr};
    endfunction

    task automatic check_cycle(input int j, input int p, input int c0, input int c1,
                               input int c2, input string tag);
        int cr[3];
        int c;
        logic [7:0] eb;
        cr[0] = c0; cr[1] = c1; cr[2] = c2;
        c = cnt_at(j, p);
        for (int ph = 0; ph < 3; ph++) begin
            eb = exp_bits(cr[ph], c, p);
            chk(cmp_o[ph*8 +: 8] == eb, tag, "comparator bits", cmp_o[ph*8 +: 8], eb);
            chk(lvl_o[ph*4 +: 4] == 4'($countones(eb)), tag, "level index",
                lvl_o[ph*4 +: 4], 4'($countones(eb)));
            chk(sw_o[ph*20 +: 20] == {exp_half(eb[7:4]), exp_half(eb[3:0])}, tag,
                "switch commands", sw_o[ph*20 +: 20],
                {exp_half(eb[7:4]), exp_half(eb[3:0])});
        end
    endtask

    task automatic check_off(input string tag);
        chk(cmp_o == '0, tag, "comparator bits off", cmp_o, 0);
        chk(lvl_o == '0, tag, "level index off", lvl_o, 0);
        chk(sw_o == {6{10'h3E0}}, tag, "switch commands off", sw_o, {6{10'h3E0}});
    endtask

    // load inputs with en low, let the offset pipe fill, then enable
    task automatic arm(input int p, input int a, input int b, input int c);
        @(negedge clk);
        per = CNT_W'(p);
        ra = REF_W'(a); rb = REF_W'(b); rc = REF_W'(c);
        en = 1'b0;
        repeat (3) @(negedge clk);
        check_off("R8");
        en = 1'b1;
    endtask

    initial begin
        // R9: reset state and first period from the valley
        per = CNT_W'(8);
        repeat (3) @(negedge clk);
        check_off("R9");
        rst = 1'b0;
        en  = 1'b1;
        for (int j = 0; j <= 16; j++) begin
            @(negedge clk);
            check_cycle(j, 8, 0, 0, 0, "R9 R1");
        end

        // vector table: R1 R2 R3 R4 R5 R7 (last entry has P=0)
        for (int i = 0; i < VN; i++) begin
            int pe;
            pe = (V_P[i] == 0) ? 1 : V_P[i];
            arm(V_P[i], V_RA[i], V_RB[i], V_RC[i]);
            for (int j = 0; j <= 2 * pe + 1; j++) begin
                @(negedge clk);
                check_cycle(j, pe, V_CA[i], V_CB[i], V_CC[i],
                            (V_P[i] == 0) ? "R7" : "R1 R2 R3 R4 R5");
            end
        end

        // R6: mid-period changes of references and P wait for the valley
        arm(100, 200, -100, -100);
        for (int j = 0; j < 50; j++) begin
            @(negedge clk);
            check_cycle(j, 100, 150, -150, -150, "R6");
        end
        per = CNT_W'(20);
        ra = REF_W'(30); rb = REF_W'(-10); rc = REF_W'(10);
        for (int j = 50; j < 200; j++) begin
            @(negedge clk);
            check_cycle(j, 100, 150, -150, -150, "R6 held");
        end
        for (int j = 200; j <= 240; j++) begin
            @(negedge clk);
            check_cycle(j - 200, 20, 20, -20, 0, "R6 reload");
        end

        // R8: enable drop mid-period forces off and restarts at the valley
        for (int j = 41; j <= 47; j++) begin
            @(negedge clk);
            check_cycle(j, 20, 20, -20, 0, "R8 pre");
        end
        en = 1'b0;
        @(negedge clk);
        check_off("R8");
        en = 1'b1;
        for (int j = 0; j <= 41; j++) begin
            @(negedge clk);
            check_cycle(j, 20, 20, -20, 0, "R8 restart");
        end

        summary();
        $finish;
    end

endmodule